// File: doc/BRIEF.md
# Peripheral Pin Remap Matrix

This block is a crossbar between a set of internal peripheral signals and a set of remappable package pins. Every peripheral input has a selector register that holds the index of the pin it listens to. Every pin has a function register that holds the code of the peripheral output that drives it. Code zero means that no function drives the pin. Pins flagged as analog are left out of the matrix in both directions. A peripheral output that reaches a pin drives it only while that peripheral's own enable is high.

All mapping registers are guarded by a lock bit. The lock bit can only be changed by a control write that comes straight after the byte 0x55 and then the byte 0xAA have been written to the key register. A key state machine tracks this sequence. Its states are KEY_IDLE, KEY_HALF and KEY_OPEN. In KEY_IDLE, a key write of 0x55 moves it to KEY_HALF, and every other access leaves it in KEY_IDLE. In KEY_HALF, a key write of 0xAA moves it to KEY_OPEN, and any other access returns it to KEY_IDLE. In KEY_OPEN, the first access of any kind returns it to KEY_IDLE. If that access is a control write, it commits a new lock value. With no access the state machine holds its state.

When the one-way input is high, a set lock cannot be cleared again until reset. The register file is read combinationally through a byte-wide bus. The system accepts one access per cycle, either a write or a read.

Top module: `pin_remap_xbar`

## Requirements
- R1: The selector register of peripheral input k is at address 0x10+k. Its value is a pin index, and a value p below NUM_PINS makes pf_in[k] follow pin_in[p]. Index 0 selects pin 0.
- R2: The function register of pin p is at address 0x20+p. A code c from 1 to NUM_FN drives pin_out[p] from fn_out[c-1], so code 5 routes fn_out[4], the second UART transmit line. Code 0, and any code above NUM_FN, is null: pin_oe[p] is 0 and pin_out[p] is 0.
- R3: The control register is at 0x01, with bit 0 as the lock bit, and the key register is at 0x00. A control write changes the lock only when it is the first access after a 0x55 key write followed at once by a 0xAA key write. Any other access in between cancels the sequence, and control writes at any other time are ignored.
- R4: While the lock is 1, writes to every selector and function register are ignored, and their read-back values are unchanged.
- R5: While one_way is 1, a lock that is 1 stays 1, even after a correctly keyed control write of 0.
- R6: After reset, the lock reads 0, every selector reads the all-ones index (so every pf_in bit is 1), and every function register reads 0 (so every pin_oe bit is 0).
- R7: pin_oe[p] is 1 only when the pin's code selects a valid function c and fn_en[c-1] is 1. When pin_oe[p] is 0, pin_out[p] is 0.
- R8: A pin with pin_analog set gives a constant 1 to any peripheral input that selects it, and its pin_oe and pin_out are 0.
- R9: A selector holding an index of NUM_PINS or above gives pf_in a constant 1.
- R10: Reads return the selector value zero-extended, the function code zero-extended, the lock in bit 0 for 0x01, and 0 for the key register and any unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| one_way | input | 1 | Makes a set lock permanent until reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (counts as an access for the key sequence) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | NUM_PINS | Digital values seen at the pins |
| pin_analog | input | NUM_PINS | Per-pin analog mode flag |
| pin_out | output | NUM_PINS | Value driven on each pin |
| pin_oe | output | NUM_PINS | Output enable of each pin |
| fn_out | input | NUM_FN | Peripheral output functions, bit c-1 for code c |
| fn_en | input | NUM_FN | Peripheral enables, one per output function |
| pf_in | output | NUM_IN | Routed values delivered to the peripheral inputs |

## Verification
The assertions assume that a cycle never carries a write and a read at the same time. They also assume that one_way changes only while reset is held. The lock-change and window-closing properties count exactly one access per cycle, and the one-way property relies on one_way being steady. The bench picks a single operation for each call of its access tasks, so the two strobes are never high together. It sets one_way only inside its reset task, and it draws random key bytes, control writes, mapping writes and reads on top of directed unlock, interrupt and override cases.

// File: rtl/pin_remap_pkg.sv
package pin_remap_pkg;
    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_BYTE_A    = 8'h55;
    localparam logic [7:0] KEY_BYTE_B    = 8'hAA;
    localparam logic [7:0] ADDR_KEY      = 8'h00;
    localparam logic [7:0] ADDR_CTRL     = 8'h01;
    localparam logic [7:0] ADDR_IN_BASE  = 8'h10;
    localparam logic [7:0] ADDR_OUT_BASE = 8'h20;
endpackage

// File: rtl/pin_remap_lockctl.sv
module pin_remap_lockctl
    import pin_remap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       one_way,
    input  logic       acc_wr,
    input  logic       acc_rd,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       lock,
    output key_state_t state
);
    key_state_t state_nxt;
    logic       any_acc;
    logic       key_wr;
    logic       commit;

    assign any_acc = acc_wr | acc_rd;
    assign key_wr  = acc_wr && (addr == ADDR_KEY);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            KEY_IDLE: if (key_wr && wdata == KEY_BYTE_A) state_nxt = KEY_HALF;
            KEY_HALF: begin
                if (key_wr && wdata == KEY_BYTE_B) state_nxt = KEY_OPEN;
                else if (any_acc)                  state_nxt = KEY_IDLE;
            end
            KEY_OPEN: if (any_acc) state_nxt = KEY_IDLE;
            default:  state_nxt = KEY_IDLE;
        endcase
    end

    assign commit = (state == KEY_OPEN) && acc_wr && (addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n)                          lock <= 1'b0;
        else if (commit && !(one_way && lock)) lock <= wdata[0];
    end
endmodule

// File: rtl/pin_remap_regs.sv
module pin_remap_regs
    import pin_remap_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_IN   = 4,
    parameter int IDX_W    = 4,
    parameter int CODE_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_wr,
    input  logic [7:0]                 addr,
    input  logic [7:0]                 wdata,
    input  logic                       lock,
    output logic [NUM_IN*IDX_W-1:0]    in_map,
    output logic [NUM_PINS*CODE_W-1:0] out_map
);
    localparam int USED_W = (IDX_W > CODE_W) ? IDX_W : CODE_W;

    logic open_wr;
    logic unused_hi;

    assign open_wr   = acc_wr && !lock;
    assign unused_hi = ^(wdata >> USED_W);

    for (genvar k = 0; k < NUM_IN; k++) begin : g_sel
        localparam logic [7:0] MY_ADDR = ADDR_IN_BASE + 8'(k);
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_map[k*IDX_W +: IDX_W] <= '1;
            else if (open_wr && addr == MY_ADDR)
                in_map[k*IDX_W +: IDX_W] <= wdata[IDX_W-1:0];
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_fn
        localparam logic [7:0] MY_ADDR = ADDR_OUT_BASE + 8'(p);
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_map[p*CODE_W +: CODE_W] <= '0;
            else if (open_wr && addr == MY_ADDR)
                out_map[p*CODE_W +: CODE_W] <= wdata[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/pin_remap_inmux.sv
module pin_remap_inmux #(
    parameter int NUM_PINS = 8,
    parameter int NUM_IN   = 4,
    parameter int IDX_W    = 4
) (
    input  logic [NUM_IN*IDX_W-1:0] in_map,
    input  logic [NUM_PINS-1:0]     pin_in,
    input  logic [NUM_PINS-1:0]     pin_analog,
    output logic [NUM_IN-1:0]       pf_in
);
    for (genvar k = 0; k < NUM_IN; k++) begin : g_in
        logic [IDX_W-1:0] sel;
        assign sel = in_map[k*IDX_W +: IDX_W];
        always_comb begin
            pf_in[k] = 1'b1;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (sel == IDX_W'(p)) pf_in[k] = pin_analog[p] ? 1'b1 : pin_in[p];
            end
        end
    end
endmodule

// File: rtl/pin_remap_outmux.sv
module pin_remap_outmux #(
    parameter int NUM_PINS = 8,
    parameter int NUM_FN   = 6,
    parameter int CODE_W   = 3
) (
    input  logic [NUM_PINS*CODE_W-1:0] out_map,
    input  logic [NUM_FN-1:0]          fn_out,
    input  logic [NUM_FN-1:0]          fn_en,
    input  logic [NUM_PINS-1:0]        pin_analog,
    output logic [NUM_PINS-1:0]        pin_out,
    output logic [NUM_PINS-1:0]        pin_oe
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_out
        logic [CODE_W-1:0] code;
        logic              drv;
        logic              en;
        assign code = out_map[p*CODE_W +: CODE_W];
        always_comb begin
            drv = 1'b0;
            en  = 1'b0;
            for (int f = 0; f < NUM_FN; f++) begin
                if (code == CODE_W'(f + 1)) begin
                    drv = fn_out[f];
                    en  = fn_en[f];
                end
            end
        end
        assign pin_oe[p]  = en && !pin_analog[p];
        assign pin_out[p] = drv && pin_oe[p];
    end
endmodule

// File: rtl/pin_remap_xbar.sv
module pin_remap_xbar
    import pin_remap_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_IN   = 4,
    parameter int NUM_FN   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                one_way,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_analog,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_FN-1:0]   fn_out,
    input  logic [NUM_FN-1:0]   fn_en,
    output logic [NUM_IN-1:0]   pf_in
);
    localparam int IDX_W  = $clog2(NUM_PINS + 1);
    localparam int CODE_W = $clog2(NUM_FN + 1);

    logic                       lock_q;
    key_state_t                 key_state;
    logic [NUM_IN*IDX_W-1:0]    in_map;
    logic [NUM_PINS*CODE_W-1:0] out_map;

    pin_remap_lockctl u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .one_way(one_way),
        .acc_wr (bus_wr),
        .acc_rd (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .lock   (lock_q),
        .state  (key_state)
    );

    pin_remap_regs #(
        .NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .IDX_W(IDX_W), .CODE_W(CODE_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_wr (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .lock   (lock_q),
        .in_map (in_map),
        .out_map(out_map)
    );

    pin_remap_inmux #(
        .NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .IDX_W(IDX_W)
    ) u_inmux (
        .in_map    (in_map),
        .pin_in    (pin_in),
        .pin_analog(pin_analog),
        .pf_in     (pf_in)
    );

    pin_remap_outmux #(
        .NUM_PINS(NUM_PINS), .NUM_FN(NUM_FN), .CODE_W(CODE_W)
    ) u_outmux (
        .out_map   (out_map),
        .fn_out    (fn_out),
        .fn_en     (fn_en),
        .pin_analog(pin_analog),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_CTRL) bus_rdata = {7'b0, lock_q};
        for (int k = 0; k < NUM_IN; k++) begin
            if (bus_addr == ADDR_IN_BASE + 8'(k))
                bus_rdata = 8'(in_map[k*IDX_W +: IDX_W]);
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            if (bus_addr == ADDR_OUT_BASE + 8'(p))
                bus_rdata = 8'(out_map[p*CODE_W +: CODE_W]);
        end
    end
endmodule

// File: rtl/pin_remap_xbar_chk.sv
module pin_remap_xbar_chk
    import pin_remap_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_IN   = 4,
    parameter int IDX_W    = 4,
    parameter int CODE_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       one_way,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [7:0]                 bus_addr,
    input logic [NUM_PINS-1:0]        pin_analog,
    input logic [NUM_PINS-1:0]        pin_oe,
    input logic                       lock,
    input logic [1:0]                 key_state,
    input logic [NUM_IN*IDX_W-1:0]    in_map,
    input logic [NUM_PINS*CODE_W-1:0] out_map
);
    AST_LOCK_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lock); // R6

    AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock != $past(lock)) |-> $past(key_state == 2'd2 && bus_wr && bus_addr == ADDR_CTRL)); // R3

    AST_WINDOW_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_state == 2'd2 && (bus_wr || bus_rd)) |=> (key_state != 2'd2)); // R3

    AST_ONE_WAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (one_way && lock) |=> lock); // R5

    AST_MAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && bus_wr) |=> ($stable(in_map) && $stable(out_map))); // R4

    AST_ANALOG_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_analog) == '0); // R8

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_null
        AST_NULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[p] |-> (out_map[p*CODE_W +: CODE_W] != '0)); // R2
    end
endmodule

bind pin_remap_xbar pin_remap_xbar_chk #(
    .NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .IDX_W(IDX_W), .CODE_W(CODE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .one_way   (one_way),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .pin_analog(pin_analog),
    .pin_oe    (pin_oe),
    .lock      (lock_q),
    .key_state (key_state),
    .in_map    (in_map),
    .out_map   (out_map)
);

// File: tb/pin_remap_xbar_tb_top.sv
module pin_remap_xbar_tb_top;
    localparam int NUM_PINS = 8;
    localparam int NUM_IN   = 4;
    localparam int NUM_FN   = 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                one_way = 1'b0;
    logic                bus_wr = 1'b0;
    logic                bus_rd = 1'b0;
    logic [7:0]          bus_addr = '0;
    logic [7:0]          bus_wdata = '0;
    logic [7:0]          bus_rdata;
    logic [NUM_PINS-1:0] pin_in = '0;
    logic [NUM_PINS-1:0] pin_analog = '0;
    logic [NUM_PINS-1:0] pin_out;
    logic [NUM_PINS-1:0] pin_oe;
    logic [NUM_FN-1:0]   fn_out = '0;
    logic [NUM_FN-1:0]   fn_en = '0;
    logic [NUM_IN-1:0]   pf_in;

    int n_checks = 0;
    int n_fail   = 0;
    int m_in [NUM_IN];
    int m_out[NUM_PINS];
    int m_lock;
    int m_state;
    logic [7:0] rd_val;

    always #5 clk = ~clk;

    pin_remap_xbar #(.NUM_PINS(NUM_PINS), .NUM_IN(NUM_IN), .NUM_FN(NUM_FN)) dut_i (
        .clk(clk), .rst_n(rst_n), .one_way(one_way),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_analog(pin_analog),
        .pin_out(pin_out), .pin_oe(pin_oe),
        .fn_out(fn_out), .fn_en(fn_en), .pf_in(pf_in)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // model of the key sequence and register file, advanced once per access
    task automatic model_step(input bit wr, input logic [7:0] a, input logic [7:0] d);
        bit commit = (m_state == 2) && wr && (a == 8'h01);
        if (wr && m_lock == 0) begin
            for (int k = 0; k < NUM_IN; k++)   if (a == 8'h10 + k) m_in[k]  = d[3:0];
            for (int p = 0; p < NUM_PINS; p++) if (a == 8'h20 + p) m_out[p] = d[2:0];
        end
        if (commit && !(one_way && m_lock == 1)) m_lock = d[0];
        case (m_state)
            0: if (wr && a == 8'h00 && d == 8'h55) m_state = 1;
            1: m_state = (wr && a == 8'h00 && d == 8'hAA) ? 2 : 0;
            default: m_state = 0;
        endcase
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_step(1'b1, a, d);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        model_step(1'b0, a, 8'h00);
    endtask

    task automatic do_reset(input logic ow);
        rst_n = 1'b0; one_way = ow;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NUM_IN; k++)   m_in[k] = 15;
        for (int p = 0; p < NUM_PINS; p++) m_out[p] = 0;
        m_lock = 0; m_state = 0;
    endtask

    task automatic keyed_ctrl(input logic [7:0] d);
        wr_reg(8'h00, 8'h55);
        wr_reg(8'h00, 8'hAA);
        wr_reg(8'h01, d);
    endtask

    function automatic int exp_read(input logic [7:0] a);
        if (a == 8'h01) return m_lock;
        for (int k = 0; k < NUM_IN; k++)   if (a == 8'h10 + k) return m_in[k];
        for (int p = 0; p < NUM_PINS; p++) if (a == 8'h20 + p) return m_out[p];
        return 0;
    endfunction

    task automatic check_model();
        logic [NUM_IN-1:0]   e_in;
        logic [NUM_PINS-1:0] e_oe;
        logic [NUM_PINS-1:0] e_out;
        #1;
        for (int k = 0; k < NUM_IN; k++) begin
            int idx = m_in[k];
            e_in[k] = (idx < NUM_PINS && !pin_analog[idx]) ? pin_in[idx] : 1'b1;
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            int c = m_out[p];
            e_oe[p]  = (c >= 1 && c <= NUM_FN) ? (fn_en[c-1] && !pin_analog[p]) : 1'b0;
            e_out[p] = e_oe[p] ? fn_out[c-1] : 1'b0;
        end
        chk("R1 pf_in", int'(pf_in), int'(e_in));
        chk("R7 pin_oe", int'(pin_oe), int'(e_oe));
        chk("R2 pin_out", int'(pin_out), int'(e_out));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd4242);
        @(negedge clk);
        do_reset(1'b0);

        // R6 reset state
        #1;
        chk("R6 pf_in", int'(pf_in), 'hF);
        chk("R6 pin_oe", int'(pin_oe), 0);
        rd_reg(8'h01, rd_val); chk("R6 lock", rd_val, 0);
        rd_reg(8'h10, rd_val); chk("R6 sel", rd_val, 15);
        rd_reg(8'h20, rd_val); chk("R6 code", rd_val, 0);

        // R1 selector 0 routes pin 0
        wr_reg(8'h11, 8'h00);
        pin_in = 8'hFE; #1 chk("R1 pin0 low", pf_in[1], 0);
        pin_in = 8'h01; #1 chk("R1 pin0 high", pf_in[1], 1);

        // R2 code 5 routes fn_out[4]; R7 enable governs
        wr_reg(8'h21, 8'h05);
        fn_out = 6'b010000; fn_en = 6'b010000;
        #1 chk("R2 oe", pin_oe[1], 1); chk("R2 out", pin_out[1], 1);
        fn_en = 6'b101111;
        #1 chk("R7 oe off", pin_oe[1], 0); chk("R7 out off", pin_out[1], 0);
        wr_reg(8'h22, 8'h07);
        fn_en = '1; fn_out = '1;
        #1 chk("R2 code 7 null", pin_oe[2], 0);

        // R3 unkeyed and interrupted control writes
        wr_reg(8'h01, 8'h01);
        rd_reg(8'h01, rd_val); chk("R3 unkeyed", rd_val, 0);
        wr_reg(8'h00, 8'h55);
        rd_reg(8'h01, rd_val);
        wr_reg(8'h00, 8'hAA);
        wr_reg(8'h01, 8'h01);
        rd_reg(8'h01, rd_val); chk("R3 interrupted", rd_val, 0);
        keyed_ctrl(8'h01);
        rd_reg(8'h01, rd_val); chk("R3 keyed set", rd_val, 1);

        // R4 locked writes ignored
        wr_reg(8'h11, 8'h03);
        rd_reg(8'h11, rd_val); chk("R4 sel frozen", rd_val, 0);
        pin_in = 8'h00; #1 chk("R4 route kept", pf_in[1], 0);

        keyed_ctrl(8'h00);
        rd_reg(8'h01, rd_val); chk("R3 keyed clear", rd_val, 0);
        wr_reg(8'h00, 8'h55); wr_reg(8'h00, 8'hAA);
        rd_reg(8'h00, rd_val); chk("R10 key reads 0", rd_val, 0);
        wr_reg(8'h01, 8'h01);
        rd_reg(8'h01, rd_val); chk("R3 window closed", rd_val, 0);

        // R8 analog pins; R9 out of range
        pin_analog = 8'h03; pin_in = 8'h00; fn_en = '1;
        #1 chk("R8 analog in", pf_in[1], 1); chk("R8 analog oe", pin_oe[1], 0);
        pin_analog = '0;
        wr_reg(8'h12, 8'h0C);
        #1 chk("R9 out of range", pf_in[2], 1);
        rd_reg(8'h12, rd_val); chk("R10 sel read", rd_val, 12);
        rd_reg(8'h7F, rd_val); chk("R10 unmapped", rd_val, 0);

        // R5 one-way lock
        do_reset(1'b1);
        keyed_ctrl(8'h01);
        keyed_ctrl(8'h00);
        rd_reg(8'h01, rd_val); chk("R5 sticky", rd_val, 1);
        do_reset(1'b1);
        rd_reg(8'h01, rd_val); chk("R6 reset clears", rd_val, 0);

        // random phases against the model
        for (int ph = 0; ph < 2; ph++) begin
            do_reset(ph[0]);
            for (int it = 0; it < 400; it++) begin
                int op = $urandom % 6;
                logic [7:0] a;
                case (op)
                    0: keyed_ctrl(8'($urandom % 2));
                    1: wr_reg(8'h00, ($urandom % 2) ? 8'h55 : (($urandom % 2) ? 8'hAA : 8'($urandom)));
                    2: wr_reg(8'h01, 8'($urandom % 2));
                    3: wr_reg(8'h10 + 8'($urandom % NUM_IN), 8'($urandom % 16));
                    4: wr_reg(8'h20 + 8'($urandom % NUM_PINS), 8'($urandom % 8));
                    default: begin
                        case ($urandom % 3)
                            0: a = 8'h01;
                            1: a = 8'h10 + 8'($urandom % NUM_IN);
                            default: a = 8'h20 + 8'($urandom % NUM_PINS);
                        endcase
                        rd_reg(a, rd_val);
                        chk("R10 readback", rd_val, exp_read(a));
                    end
                endcase
                pin_in = 8'($urandom); fn_out = 6'($urandom); fn_en = 6'($urandom);
                pin_analog = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
                check_model();
            end
        end
        summary();
    end
endmodule